// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Controller

This block is the host end of a serial link to a chain of identical converter devices. All devices share one chip-select line, which also starts their conversions, and one serial clock. The host data output feeds the first device. Each device passes its shift-register output on to the next device, and the last device's output returns to the host data input. One frame moves a full command word into every device and reads a full result word out of every device.

A user loads the concatenated command vector and pulses `start`. The controller pulls chip-select low and runs exactly 32 clock capture edges per device, shifting data MSB-first. It then raises chip-select, which is the moment when every device acts on its new command, and pulses `done`. The returned bits arrive farthest-device-first. They are split into one 32-bit slice per device on `rsp_out`, and those slices stay valid until the next frame ends. The user must write the same configuration value into every device slice, with the devices set to a single-output legacy mode.

Chip-select then stays high for a programmable minimum time, which stands in for the conversion time. The serial clock rate is set by a divider of the system clock.

Top module: `dchain_frame_ctrl`

## Requirements
- R1: During and after reset, before any frame: `cs_n`=1, `sclk`=0, `done`=0, `busy`=0 and `rsp_out` is all zeros.
- R2: An accepted `start` pulls `cs_n` low at the next clock edge. `cs_n` stays low for exactly (2·FB+1)·DIV cycles, where FB = N_DEV·WORD_W. During that time `sclk` makes exactly FB rising edges, and `sclk` is never high while `cs_n` is high.
- R3: `sclk` idles low. Its first rise comes DIV cycles after `cs_n` falls, and every high and low level lasts DIV cycles.
- R4: `mosi` sends the `cmd_in` value captured at the accepted `start`, MSB first (bit FB-1 first). The top slice, which is the farthest device's word, therefore leads. A new bit appears only together with a falling `sclk`, and `mosi` is steady while `sclk` is high.
- R5: `miso` is sampled at each rising `sclk`. The first bit received lands in `rsp_out[FB-1]`. As a result, slice `rsp_out[d*WORD_W +: WORD_W]` holds the word returned by device d+1, counted from the host output.
- R6: `done` is high for exactly one cycle, and that cycle is the one in which `cs_n` returns high. `rsp_out` changes only in that cycle and holds its value until the next frame ends.
- R7: Between frames `cs_n` stays high for at least GAP_MIN cycles. A `start` that is held high is accepted exactly GAP_MIN cycles after `cs_n` rose. After reset, the first `start` is accepted at once.
- R8: A `start` that arrives while a frame is running, or inside the minimum gap, is ignored. Changes to `cmd_in` during a frame do not reach `mosi`.
- R9: After a frame through a chain of 32-bit shift registers, device d+1 holds `cmd_in[d*WORD_W +: WORD_W]`.
- R10: `busy` is high from the edge that accepts `start` up to the edge at which `cs_n` rises, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame |
| cmd_in | input | N_DEV*WORD_W | Concatenated commands; slice d is for device d+1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse as chip-select returns high |
| rsp_out | output | N_DEV*WORD_W | Returned words; slice d came from device d+1 |
| cs_n | output | 1 | Shared chip-select / convert start, active low |
| sclk | output | 1 | Shared serial clock, idles low |
| mosi | output | 1 | Serial data to the first device |
| miso | input | 1 | Serial data from the last device |

## Verification
The assertions watch these rules on every cycle:
- the frame length and the count of capture edges;
- the level widths of `sclk`;
- `mosi` staying steady while `sclk` is high;
- `done` coinciding with the rise of `cs_n`;
- `rsp_out` holding between frames;
- the minimum gap with `cs_n` high;
- `busy` covering the frame.

Some behaviour only the bench's scenarios can show, because it needs a model of the chain. These are the bit ordering that puts each command into the right device, the splitting of the returned stream into per-device slices, the exact cycle at which a held `start` is accepted, and the rejection of `start` pulses and `cmd_in` changes in the middle of a frame.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_END} fr_state_t;

  // Total serial bits in one frame.
  function automatic int frame_bits(input int n_dev, input int word_w);
    return n_dev * word_w;
  endfunction

  // System-clock cycles with chip-select low: FB clock periods plus a closing half period.
  function automatic int frame_cycles(input int n_dev, input int word_w, input int div);
    return (2 * n_dev * word_w + 1) * div;
  endfunction
endpackage

// File: rtl/dchain_tick.sv
module dchain_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dchain_gap.sv
module dchain_gap #(
  parameter int GAP_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);
  localparam int GW = $clog2(GAP_MIN + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_MIN);

  logic [GW-1:0] cnt_q;

  assign ready = (cnt_q >= GAP_V);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= GAP_V;
    else if (restart) cnt_q <= GW'(1);
    else if (cnt_q < GAP_V) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dchain_shift.sv
module dchain_shift #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_shift,
  input  logic         rx_shift,
  input  logic         rx_bit,
  output logic         tx_msb,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  assign tx_msb  = tx_q[W-1];
  assign rx_word = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= '0;
    else if (load) tx_q <= load_val;
    else if (tx_shift) tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= '0;
    else if (rx_shift) rx_q <= {rx_q[W-2:0], rx_bit};
  end
endmodule

// File: rtl/dchain_frame_ctrl.sv
module dchain_frame_ctrl #(
  parameter int N_DEV   = 3,
  parameter int WORD_W  = 32,
  parameter int DIV     = 2,
  parameter int GAP_MIN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N_DEV*WORD_W-1:0]   cmd_in,
  output logic                      busy,
  output logic                      done,
  output logic [N_DEV*WORD_W-1:0]   rsp_out,
  output logic                      cs_n,
  output logic                      sclk,
  output logic                      mosi,
  input  logic                      miso
);
  import dchain_pkg::*;

  localparam int FB    = frame_bits(N_DEV, WORD_W);
  localparam int CNT_W = $clog2(FB + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FB);

  fr_state_t        state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             cs_q, sclk_q, done_q;
  logic [FB-1:0]    rsp_q;

  // Named internal events, also observed by the checker.
  logic tick, gap_ok, last_bit;
  logic accept_evt, capture_evt, launch_evt, frame_end_evt;
  logic tx_msb;
  logic [FB-1:0] rx_word;

  assign last_bit      = (bit_cnt_q == LAST_BIT);
  assign accept_evt    = start && (state_q == ST_IDLE) && gap_ok;
  assign capture_evt   = (state_q == ST_LOW) && tick;
  assign launch_evt    = (state_q == ST_HIGH) && tick && !last_bit;
  assign frame_end_evt = (state_q == ST_END) && tick;

  dchain_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q != ST_IDLE),
    .tick (tick)
  );

  dchain_gap #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(frame_end_evt),
    .ready  (gap_ok)
  );

  dchain_shift #(.W(FB)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_evt),
    .load_val(cmd_in),
    .tx_shift(launch_evt),
    .rx_shift(capture_evt),
    .rx_bit  (miso),
    .tx_msb  (tx_msb),
    .rx_word (rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      rsp_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_evt) begin
          state_q   <= ST_LOW;
          cs_q      <= 1'b0;
          bit_cnt_q <= '0;
        end
        ST_LOW: if (tick) begin
          state_q   <= ST_HIGH;
          sclk_q    <= 1'b1;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        ST_HIGH: if (tick) begin
          sclk_q  <= 1'b0;
          state_q <= last_bit ? ST_END : ST_LOW;
        end
        ST_END: if (tick) begin
          state_q <= ST_IDLE;
          cs_q    <= 1'b1;
          done_q  <= 1'b1;
          rsp_q   <= rx_word;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign rsp_out = rsp_q;
  assign cs_n    = cs_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_msb;
endmodule

// File: rtl/dchain_frame_chk.sv
module dchain_frame_chk #(
  parameter int N_DEV   = 3,
  parameter int WORD_W  = 32,
  parameter int DIV     = 2,
  parameter int GAP_MIN = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cs_n,
  input logic                    sclk,
  input logic                    mosi,
  input logic                    busy,
  input logic                    done,
  input logic [N_DEV*WORD_W-1:0] rsp_out,
  input logic                    capture_evt,
  input logic                    frame_end_evt
);
  localparam int FB  = dchain_pkg::frame_bits(N_DEV, WORD_W);
  localparam int FC  = dchain_pkg::frame_cycles(N_DEV, WORD_W, DIV);
  localparam int CW  = $clog2(FB + 2);
  localparam int LW  = $clog2(FC + 2);
  localparam int HW  = $clog2(DIV + 2) + 1;
  localparam int GW  = $clog2(GAP_MIN + 2) + 1;

  logic [CW-1:0] cap_cnt;
  logic [LW-1:0] low_cnt;
  logic [HW-1:0] lvl_cnt;
  logic [GW-1:0] hi_cnt;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt <= '0;
      low_cnt <= '0;
      lvl_cnt <= '0;
      hi_cnt  <= GW'(GAP_MIN);
      sclk_d  <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (frame_end_evt) cap_cnt <= '0;
      else if (capture_evt) cap_cnt <= cap_cnt + 1'b1;
      low_cnt <= cs_n ? '0 : low_cnt + 1'b1;
      if (sclk != sclk_d) lvl_cnt <= HW'(1);
      else if (lvl_cnt <= HW'(DIV)) lvl_cnt <= lvl_cnt + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < GW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  p_capture_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_evt |-> (cap_cnt == CW'(FB)));
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (low_cnt == LW'(FC)));
  p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (lvl_cnt == HW'(DIV)));
  p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  p_capture_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (!cs_n && !sclk));
  p_done_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rsp_out));
  p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= GW'(GAP_MIN)));
  p_busy_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind dchain_frame_ctrl dchain_frame_chk #(
  .N_DEV(N_DEV), .WORD_W(WORD_W), .DIV(DIV), .GAP_MIN(GAP_MIN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .mosi         (mosi),
  .busy         (busy),
  .done         (done),
  .rsp_out      (rsp_out),
  .capture_evt  (capture_evt),
  .frame_end_evt(frame_end_evt)
);

// File: tb/dchain_frame_ctrl_tb.sv
module dchain_frame_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV   = 3;
  localparam int WORD_W  = 32;
  localparam int DIV     = 2;
  localparam int GAP_MIN = 4;
  localparam int FB      = N_DEV * WORD_W;
  localparam int FRAME_CYC = (2 * FB + 1) * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FB-1:0] cmd_in = '0;
  logic busy, done, cs_n, sclk, mosi, miso;
  logic [FB-1:0] rsp_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dchain_frame_ctrl #(.N_DEV(N_DEV), .WORD_W(WORD_W), .DIV(DIV), .GAP_MIN(GAP_MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in), .busy(busy), .done(done),
    .rsp_out(rsp_out), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Chain of device shift registers: device index 0 is nearest the host.
  logic [FB-1:0]     resp_vec = '0;
  logic [WORD_W-1:0] dev_sr  [N_DEV];
  logic [WORD_W-1:0] dev_got [N_DEV];
  logic              dev_sdo [N_DEV];

  initial begin
    for (int d = 0; d < N_DEV; d++) begin
      dev_sr[d] = '0; dev_got[d] = '0; dev_sdo[d] = 1'b0;
    end
  end

  assign miso = dev_sdo[N_DEV-1];

  always @(negedge cs_n) begin
    for (int d = 0; d < N_DEV; d++) begin
      dev_sr[d]  = resp_vec[d*WORD_W +: WORD_W];
      dev_sdo[d] = resp_vec[d*WORD_W + WORD_W - 1];
    end
  end

  always @(posedge sclk) if (!cs_n) begin
    for (int d = 0; d < N_DEV; d++)
      dev_sr[d] = {dev_sr[d][WORD_W-2:0], (d == 0) ? mosi : dev_sdo[d-1]};
  end

  always @(negedge sclk) if (!cs_n) begin
    for (int d = 0; d < N_DEV; d++) dev_sdo[d] = dev_sr[d][WORD_W-1];
  end

  always @(posedge cs_n) begin
    for (int d = 0; d < N_DEV; d++) dev_got[d] = dev_sr[d];
  end

  // Behavioural reference: m_k counts cycles since the accepting edge, -1 when idle.
  int            m_k = -1;
  int            m_gap = GAP_MIN;
  bit            m_done = 1'b0;
  logic [FB-1:0] m_cmd = '0;
  logic [FB-1:0] m_rsp = '0;

  always @(posedge clk) begin
    m_done = 1'b0;
    if (!rst_n) begin
      m_k = -1; m_gap = GAP_MIN; m_rsp = '0;
    end else if (m_k < 0) begin
      if (start && m_gap >= GAP_MIN) begin
        m_k = 0; m_cmd = cmd_in;
      end else if (m_gap < GAP_MIN) m_gap++;
    end else begin
      m_k++;
      if (m_k == FRAME_CYC) begin
        m_k = -1; m_gap = 1; m_done = 1'b1; m_rsp = resp_vec;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e_cs, e_sclk, e_busy;
    int b;
    e_cs   = (m_k < 0);
    e_busy = (m_k >= 0);
    e_sclk = (m_k >= 0) && (((m_k / DIV) % 2) == 1);
    chk(cs_n == e_cs, "R2", "cs_n", FB'(cs_n), FB'(e_cs));
    chk(sclk == e_sclk, "R3", "sclk", FB'(sclk), FB'(e_sclk));
    chk(busy == e_busy, "R10", "busy", FB'(busy), FB'(e_busy));
    chk(done == m_done, "R6", "done", FB'(done), FB'(m_done));
    chk(rsp_out == m_rsp, "R6", "rsp_out held", rsp_out, m_rsp);
    if (!e_cs) begin
      b = m_k / (2 * DIV);
      if (b > FB - 1) b = FB - 1;
      chk(mosi == m_cmd[FB-1-b], "R4", "mosi bit", FB'(mosi), FB'(m_cmd[FB-1-b]));
    end
  end

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [FB-1:0] mk_vec(input logic [WORD_W-1:0] base, input int step);
    logic [FB-1:0] v;
    for (int d = 0; d < N_DEV; d++) v[d*WORD_W +: WORD_W] = base ^ WORD_W'(d * step);
    return v;
  endfunction

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic check_frame(input logic [FB-1:0] c, input logic [FB-1:0] r);
    for (int d = 0; d < N_DEV; d++) begin
      chk(dev_got[d] == c[d*WORD_W +: WORD_W], "R9", $sformatf("device %0d command", d + 1),
          FB'(dev_got[d]), FB'(c[d*WORD_W +: WORD_W]));
      chk(rsp_out[d*WORD_W +: WORD_W] == r[d*WORD_W +: WORD_W], "R5",
          $sformatf("slice %0d result", d), FB'(rsp_out[d*WORD_W +: WORD_W]),
          FB'(r[d*WORD_W +: WORD_W]));
    end
  endtask

  task automatic do_frame(input logic [FB-1:0] c, input logic [FB-1:0] r, input bit poke);
    resp_vec = r; cmd_in = c; start = 1'b1;
    do @(negedge clk); while (!busy);
    start = 1'b0;
    if (poke) begin
      // R8: a request and a new command in mid-frame must change nothing.
      repeat (25) @(negedge clk);
      cmd_in = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    check_frame(c, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n in reset", FB'(cs_n), FB'(1));
    chk(sclk == 1'b0, "R1", "sclk in reset", FB'(sclk), FB'(0));
    chk(done == 1'b0, "R1", "done in reset", FB'(done), FB'(0));
    chk(busy == 1'b0, "R1", "busy in reset", FB'(busy), FB'(0));
    chk(rsp_out == '0, "R1", "rsp_out in reset", rsp_out, '0);
    rst_n = 1'b1;
    @(negedge clk);

    do_frame(mk_vec(32'hC3A5_0F10, 32'h0101_0101), mk_vec(32'h1234_5678, 32'h1111_0000), 1'b0);
    // R7/R8: a pulse inside the gap is ignored (the model keeps cs_n high).
    cmd_in = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (GAP_MIN + 2) @(negedge clk);
    chk(cs_n == 1'b1, "R8", "cs_n after gap pulse", FB'(cs_n), FB'(1));

    do_frame({FB{1'b1}}, '0, 1'b1);
    // R7: held start straight after done, accepted exactly at gap end (model compares).
    do_frame({(FB/2){2'b01}}, {(FB/2){2'b10}}, 1'b0);
    do_frame('0, {FB{1'b1}}, 1'b1);
    do_frame(mk_vec(32'h8000_0001, 32'h0000_0100), mk_vec(32'hFEDC_BA98, 32'h0F0F_0F0F), 1'b0);
    repeat (10) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule